// File: doc/BRIEF.md
# Interrupt-capable GPIO bank

This block is a bank of general-purpose I/O lines sitting behind a small memory-mapped register port. A register access takes one cycle: an address, a write strobe and write data come in, and read data returns combinationally from the addressed register. Every line has four controls. It has an output level and a direction. It can be set to blink, so that the driven level toggles at a fixed rate. It also has a polarity bit that inverts the sampled input.

Pin inputs are synchronized and then XORed with their polarity bit. The resulting value is what software reads back. It is also what both interrupt paths see. A level path gates this value through a level mask and is not latched. An edge path latches a 0-to-1 transition of the value into a sticky cause register. Software acknowledges a cause by writing zeros to it. Pending causes are ORed over groups of eight lines, one interrupt wire per group.

A build-time option adds a second processor. That processor has its own edge and level masks and its own group interrupts, and it shares the edge-cause register with the first processor.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all registers read 0, `pin_oe` is all ones (every line is an output), `pin_out` is 0 and no interrupt output is high.
- R2: Writable registers sit at these byte offsets: output value 0x00, direction 0x04, blink 0x08, polarity 0x0C, edge cause 0x14, processor-0 edge mask 0x18, processor-0 level mask 0x1C. Each reads back what was written. A direction bit of 1 makes the line an input, so `pin_oe` bit = NOT direction bit.
- R3: `pin_out` bit = output bit XOR (blink bit AND blink phase). The phase toggles once every `BLINK_HALF` clock cycles. With blink bit 0, `pin_out` follows the output register alone.
- R4: Offset 0x10 is read-only. It returns the two-flop-synchronized pin level XOR the polarity bit, and becomes valid two clocks after a pin change. Writes to 0x10 change nothing.
- R5: An edge-cause bit is set when its polarized value goes from 0 to 1. Polarity 0 therefore catches a rising pin and polarity 1 a falling pin. The bit reads as set three clocks after the pin change.
- R6: A write to 0x14 clears every cause bit written 0 and keeps every bit written 1. Cause bits never clear by any other means.
- R7: A new edge in the same cycle as a write that clears the same bit leaves that bit set.
- R8: Pending for a processor = (polarized input AND level mask) OR (cause AND edge mask). The level term is not latched. Interrupt output bit g is the OR of pending over lines 8g to 8g+7.
- R9: With the second processor enabled, its edge mask is at 0x30 and its level mask at 0x34. These drive `irq_cpu1` from the shared cause register and polarized input, independently of `irq_cpu0`.
- R10: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | LINES | Write data |
| reg_rdata | output | LINES | Read data of the addressed register |
| pin_in | input | LINES | Asynchronous pin levels |
| pin_out | output | LINES | Driven pin levels |
| pin_oe | output | LINES | Output enable per line, 1 = drive |
| irq_cpu0 | output | LINES/GROUP | Grouped interrupts of processor 0 |
| irq_cpu1 | output | LINES/GROUP | Grouped interrupts of processor 1, 0 when the option is off |

## Verification
The properties assume that `reg_we` is a clean one-cycle strobe with a stable address and data in that cycle. They also assume that `pin_in` may change at any clock but is treated only through the synchronizer. The bench drives all register and pin inputs half a cycle away from the active edge, so they are stable across every sampling edge. It times the clear-versus-edge collision by counting the three synchronizer and detection stages. Random traffic touches only offsets from the map plus one unmapped offset. This keeps the cause-hold and edge-wins properties meaningful.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_OUT    = 8'h00;
    localparam logic [7:0] OFS_DIR    = 8'h04;
    localparam logic [7:0] OFS_BLINK  = 8'h08;
    localparam logic [7:0] OFS_POL    = 8'h0C;
    localparam logic [7:0] OFS_DIN    = 8'h10;
    localparam logic [7:0] OFS_CAUSE  = 8'h14;
    localparam logic [7:0] OFS_EMASK0 = 8'h18;
    localparam logic [7:0] OFS_LMASK0 = 8'h1C;
    localparam logic [7:0] OFS_EMASK1 = 8'h30;
    localparam logic [7:0] OFS_LMASK1 = 8'h34;

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] polarity,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = pin_in;
        s_d.stable = s_q.meta;
        s_d.last   = s_q.stable ^ polarity;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.stable ^ polarity;
    assign rise_o  = level_o & ~s_q.last;

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int unsigned HALF_PERIOD = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);

    localparam int unsigned CNT_W = $clog2(HALF_PERIOD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } blink_t;

    blink_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (b_q.cnt == LAST) begin
            b_d.cnt   = '0;
            b_d.phase = ~b_q.phase;
        end else begin
            b_d.cnt = b_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign phase_o = b_q.phase;

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int unsigned LINES = 32,
    parameter int unsigned GROUP = 8,
    localparam int unsigned NG   = LINES / GROUP
) (
    input  logic [LINES-1:0] level_i,
    input  logic [LINES-1:0] cause_i,
    input  logic [LINES-1:0] emask_i,
    input  logic [LINES-1:0] lmask_i,
    output logic [NG-1:0]    irq_o
);

    logic [LINES-1:0] pending;

    assign pending = (level_i & lmask_i) | (cause_i & emask_i);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign irq_o[g] = |pending[g*GROUP +: GROUP];
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned LINES      = 32,
    parameter int unsigned GROUP      = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned BLINK_HALF = 1000000,
    parameter bit          DUAL_CPU   = 1'b1,
    localparam int unsigned NG        = LINES / GROUP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic [NG-1:0]     irq_cpu0,
    output logic [NG-1:0]     irq_cpu1
);

    localparam int unsigned NCPU = DUAL_CPU ? 2 : 1;

    typedef struct packed {
        logic [LINES-1:0]           out;
        logic [LINES-1:0]           dir;
        logic [LINES-1:0]           blink;
        logic [LINES-1:0]           pol;
        logic [LINES-1:0]           cause;
        logic [NCPU-1:0][LINES-1:0] emask;
        logic [NCPU-1:0][LINES-1:0] lmask;
    } bank_t;

    bank_t st_d, st_q;

    logic [LINES-1:0] din_pol;
    logic [LINES-1:0] edge_now;
    logic [LINES-1:0] cause_now;
    logic [LINES-1:0] blink_now;
    logic [LINES-1:0] em_c0, lm_c0, em_c1, lm_c1;
    logic [LINES-1:0] clr_keep;
    logic             phase;
    logic [NCPU-1:0][NG-1:0] irq_all;

    gpio_sync_edge #(.WIDTH(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .polarity (st_q.pol),
        .level_o  (din_pol),
        .rise_o   (edge_now)
    );

    gpio_blink_gen #(.HALF_PERIOD(BLINK_HALF)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    // Next-state: register writes and edge-cause latching
    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            case (reg_addr)
                ADDR_W'(OFS_OUT):    st_d.out      = reg_wdata;
                ADDR_W'(OFS_DIR):    st_d.dir      = reg_wdata;
                ADDR_W'(OFS_BLINK):  st_d.blink    = reg_wdata;
                ADDR_W'(OFS_POL):    st_d.pol      = reg_wdata;
                ADDR_W'(OFS_EMASK0): st_d.emask[0] = reg_wdata;
                ADDR_W'(OFS_LMASK0): st_d.lmask[0] = reg_wdata;
                ADDR_W'(OFS_EMASK1): if (NCPU > 1) st_d.emask[NCPU-1] = reg_wdata;
                ADDR_W'(OFS_LMASK1): if (NCPU > 1) st_d.lmask[NCPU-1] = reg_wdata;
                default: ;
            endcase
        end
        clr_keep = (reg_we && reg_addr == ADDR_W'(OFS_CAUSE)) ? reg_wdata : '1;
        // New edges are ORed after the clear, so they win a collision
        st_d.cause = (st_q.cause & clr_keep) | edge_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        case (reg_addr)
            ADDR_W'(OFS_OUT):    reg_rdata = st_q.out;
            ADDR_W'(OFS_DIR):    reg_rdata = st_q.dir;
            ADDR_W'(OFS_BLINK):  reg_rdata = st_q.blink;
            ADDR_W'(OFS_POL):    reg_rdata = st_q.pol;
            ADDR_W'(OFS_DIN):    reg_rdata = din_pol;
            ADDR_W'(OFS_CAUSE):  reg_rdata = st_q.cause;
            ADDR_W'(OFS_EMASK0): reg_rdata = st_q.emask[0];
            ADDR_W'(OFS_LMASK0): reg_rdata = st_q.lmask[0];
            ADDR_W'(OFS_EMASK1): reg_rdata = em_c1;
            ADDR_W'(OFS_LMASK1): reg_rdata = lm_c1;
            default:             reg_rdata = '0;
        endcase
    end

    assign cause_now = st_q.cause;
    assign blink_now = st_q.blink;
    assign em_c0     = st_q.emask[0];
    assign lm_c0     = st_q.lmask[0];
    assign em_c1     = (NCPU > 1) ? st_q.emask[NCPU-1] : '0;
    assign lm_c1     = (NCPU > 1) ? st_q.lmask[NCPU-1] : '0;

    assign pin_oe  = ~st_q.dir;
    assign pin_out = st_q.out ^ (blink_now & {LINES{phase}});

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        gpio_irq_group #(.LINES(LINES), .GROUP(GROUP)) u_grp (
            .level_i (din_pol),
            .cause_i (cause_now),
            .emask_i (st_q.emask[c]),
            .lmask_i (st_q.lmask[c]),
            .irq_o   (irq_all[c])
        );
    end

    assign irq_cpu0 = irq_all[0];

    if (NCPU > 1) begin : g_irq1
        assign irq_cpu1 = irq_all[NCPU-1];
    end else begin : g_irq1_off
        assign irq_cpu1 = '0;
    end

endmodule

// File: rtl/gpio_irq_bank_checker.sv
module gpio_irq_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int unsigned LINES  = 32,
    parameter int unsigned NG     = 4,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [LINES-1:0]  reg_wdata,
    input logic [LINES-1:0]  pin_out,
    input logic [LINES-1:0]  pin_oe,
    input logic [NG-1:0]     irq_cpu0,
    input logic [NG-1:0]     irq_cpu1,
    input logic [LINES-1:0]  cause_now,
    input logic [LINES-1:0]  edge_now,
    input logic [LINES-1:0]  blink_now,
    input logic [LINES-1:0]  em_c0,
    input logic [LINES-1:0]  lm_c0,
    input logic [LINES-1:0]  em_c1,
    input logic [LINES-1:0]  lm_c1
);

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == ~$past(reg_wdata)));

    p_blink_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && blink_now == '0) |=> $stable(pin_out));

    p_cause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(OFS_CAUSE)) |=> (($past(cause_now) & ~cause_now) == '0));

    p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now != '0) |=> ((cause_now & $past(edge_now)) == $past(edge_now)));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (em_c0 == '0 && lm_c0 == '0) |-> (irq_cpu0 == '0));

    p_cpu1_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (em_c1 == '0 && lm_c1 == '0) |-> (irq_cpu1 == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_checker #(
    .LINES  (LINES),
    .NG     (NG),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_cpu0  (irq_cpu0),
    .irq_cpu1  (irq_cpu1),
    .cause_now (cause_now),
    .edge_now  (edge_now),
    .blink_now (blink_now),
    .em_c0     (em_c0),
    .lm_c0     (lm_c0),
    .em_c1     (em_c1),
    .lm_c1     (lm_c1)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic [3:0]  irq_cpu0, irq_cpu1;

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_bank #(
        .LINES(32), .GROUP(8), .ADDR_W(8), .BLINK_HALF(HALF), .DUAL_CPU(1'b1)
    ) u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_out = '0, m_dir = '0, m_blk = '0, m_pol = '0, m_cause = '0;
    logic [31:0] m_em0 = '0, m_lm0 = '0, m_em1 = '0, m_lm1 = '0;
    logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    int          m_cnt = 0;
    logic        m_phase = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out = '0; m_dir = '0; m_blk = '0; m_pol = '0; m_cause = '0;
            m_em0 = '0; m_lm0 = '0; m_em1 = '0; m_lm1 = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_cnt = 0; m_phase = 1'b0;
        end else begin
            logic [31:0] now_v, keep;
            now_v = m_s2 ^ m_pol;
            keep  = (reg_we && reg_addr == 8'h14) ? reg_wdata : 32'hFFFF_FFFF;
            m_cause = (m_cause & keep) | (now_v & ~m_prev);
            m_prev  = now_v;
            m_s2    = m_s1;
            m_s1    = pin_in;
            if (reg_we) begin
                case (reg_addr)
                    8'h00: m_out = reg_wdata;
                    8'h04: m_dir = reg_wdata;
                    8'h08: m_blk = reg_wdata;
                    8'h0C: m_pol = reg_wdata;
                    8'h18: m_em0 = reg_wdata;
                    8'h1C: m_lm0 = reg_wdata;
                    8'h30: m_em1 = reg_wdata;
                    8'h34: m_lm1 = reg_wdata;
                    default: ;
                endcase
            end
            if (m_cnt == HALF - 1) begin
                m_cnt = 0;
                m_phase = ~m_phase;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_out;
            8'h04: return m_dir;
            8'h08: return m_blk;
            8'h0C: return m_pol;
            8'h10: return m_s2 ^ m_pol;
            8'h14: return m_cause;
            8'h18: return m_em0;
            8'h1C: return m_lm0;
            8'h30: return m_em1;
            8'h34: return m_lm1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [3:0] m_irq(input logic [31:0] em, input logic [31:0] lm);
        logic [31:0] pend;
        logic [3:0]  r;
        pend = ((m_s2 ^ m_pol) & lm) | (m_cause & em);
        for (int g = 0; g < 4; g++) r[g] = (((pend >> (g * 8)) & 32'hFF) != 0);
        return r;
    endfunction

    function automatic string rd_req(input logic [7:0] a);
        case (a)
            8'h10: return "R4";
            8'h14: return "R5";
            8'h30, 8'h34: return "R9";
            8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C: return "R2";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n && cmp_en) begin
            chk("R2", "pin_oe", pin_oe, ~m_dir);
            chk("R3", "pin_out", pin_out, m_out ^ (m_blk & {32{m_phase}}));
            chk("R8", "irq_cpu0", {28'd0, irq_cpu0}, {28'd0, m_irq(m_em0, m_lm0)});
            chk("R9", "irq_cpu1", {28'd0, irq_cpu1}, {28'd0, m_irq(m_em1, m_lm1)});
            chk(rd_req(reg_addr), "reg_rdata", reg_rdata, m_read(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #3;
        chk(req, "directed read", reg_rdata, exp);
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    logic [7:0] addr_list [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                    8'h18, 8'h1C, 8'h30, 8'h34, 8'h24};

    initial begin
        logic [31:0] a_snap, b_snap;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        rd(8'h00, 32'h0, "R1");
        rd(8'h04, 32'h0, "R1");
        rd(8'h14, 32'h0, "R1");
        rd(8'h18, 32'h0, "R1");
        chk("R1", "pin_oe reset", pin_oe, 32'hFFFF_FFFF);
        chk("R1", "irq reset", {24'd0, irq_cpu1, irq_cpu0}, 32'h0);

        // R2 map and direction
        wr(8'h00, 32'hA5A5_0F0F);
        wr(8'h04, 32'hFFFF_0000);
        rd(8'h00, 32'hA5A5_0F0F, "R2");
        rd(8'h04, 32'hFFFF_0000, "R2");
        chk("R2", "pin_oe dir", pin_oe, 32'h0000_FFFF);
        chk("R3", "pin_out steady", pin_out, 32'hA5A5_0F0F);

        // R3 blink toggles once per HALF cycles
        wr(8'h08, 32'h0000_00FF);
        @(negedge clk); #3; a_snap = pin_out;
        idle(HALF); #3; b_snap = pin_out;
        chk("R3", "blink toggle", a_snap ^ b_snap, 32'h0000_00FF);
        wr(8'h08, 32'h0);

        // R4 data-in with polarity; read-only
        pins(32'h1234_5678);
        idle(3);
        rd(8'h10, 32'h1234_5678, "R4");
        wr(8'h0C, 32'hFFFF_0000);
        rd(8'h10, 32'hEDCB_5678, "R4");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'hEDCB_5678, "R4");
        rd(8'h0C, 32'hFFFF_0000, "R4");
        wr(8'h0C, 32'h0);
        pins(32'h0);
        idle(3);
        wr(8'h14, 32'h0);
        rd(8'h14, 32'h0, "R6");

        // R5 / R8 edge causes and grouping
        wr(8'h18, 32'h0000_0101);
        pins(32'h0000_0001);
        idle(3);
        rd(8'h14, 32'h0000_0001, "R5");
        chk("R8", "irq group0", {28'd0, irq_cpu0}, 32'h1);
        pins(32'h0000_0101);
        idle(3);
        #3;
        chk("R8", "irq groups0+1", {28'd0, irq_cpu0}, 32'h3);

        // R6 acknowledge one line
        wr(8'h14, 32'hFFFF_FFFE);
        rd(8'h14, 32'h0000_0100, "R6");
        chk("R6", "irq after ack", {28'd0, irq_cpu0}, 32'h2);

        // R5 falling edge with polarity set
        wr(8'h0C, 32'h0000_0100);
        wr(8'h14, 32'hFFFF_FEFF);
        rd(8'h14, 32'h0, "R6");
        pins(32'h0000_0001);
        idle(3);
        rd(8'h14, 32'h0000_0100, "R5");

        // R7 edge collides with clear
        wr(8'h14, 32'h0);
        rd(8'h14, 32'h0, "R6");
        pins(32'h0000_0003);
        idle(1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h0;
        @(negedge clk);
        reg_we = 1'b0;
        rd(8'h14, 32'h0000_0002, "R7");

        // R8 level path not latched
        wr(8'h1C, 32'h0001_0000);
        pins(32'h0001_0003);
        idle(2);
        #3;
        chk("R8", "level high", {28'd0, irq_cpu0}, 32'h4);
        pins(32'h0000_0003);
        idle(2);
        #3;
        chk("R8", "level released", {28'd0, irq_cpu0}, 32'h0);

        // R9 second processor
        wr(8'h14, 32'h0);
        wr(8'h30, 32'h0100_0000);
        pins(32'h0100_0003);
        idle(3);
        #3;
        chk("R9", "cpu1 edge", {28'd0, irq_cpu1}, 32'h8);
        chk("R9", "cpu0 unaffected", {28'd0, irq_cpu0}, 32'h0);
        rd(8'h30, 32'h0100_0000, "R9");
        wr(8'h34, 32'h0000_0002);
        #3;
        chk("R9", "cpu1 level", {28'd0, irq_cpu1}, 32'h9);

        // R10 unmapped offset
        wr(8'h24, 32'hDEAD_BEEF);
        rd(8'h24, 32'h0, "R10");
        rd(8'h00, 32'hA5A5_0F0F, "R10");

        // Random traffic against the model
        for (int i = 0; i < 1500; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            @(negedge clk);
            reg_we = 1'b0;
            if (sel < 3) begin
                pin_in = $urandom;
            end else if (sel < 6) begin
                reg_we    = 1'b1;
                reg_addr  = addr_list[$urandom_range(0, 10)];
                reg_wdata = (reg_addr == 8'h14) ? ~(32'h1 << $urandom_range(0, 31)) : $urandom;
            end else begin
                reg_addr = addr_list[$urandom_range(0, 10)];
            end
        end
        @(negedge clk);
        reg_we = 1'b0;
        idle(4);
        finish_run();
    end

endmodule